// File: doc/BRIEF.md
# Clock Gear Divider

This block produces an internal operating clock from an oscillator by two division stages in series. An optional halving stage comes first. A gear stage follows that divides by 1, 2, 4 or 8. The output duty is deliberately uneven. The low phase always lasts half of one source period, where the source is the oscillator after the optional halving. Every other part of the output period is high. At slow gears the result is a long high phase with a short low phase.

The block runs on a timing clock `clk` whose rate is twice the oscillator rate. One `clk` period, called a tick here, therefore equals half an oscillator period, and every phase the block produces is a whole number of ticks. The output `gear_clk` comes straight from a register. `cyc_start` is a one-tick strobe on the tick where each output period begins. Downstream logic in the `clk` domain can use it as an enable.

A new halving or gear selection is taken only on the tick where a new output period begins. The period already in progress always runs to its end, so a change of selection can never produce a shortened high or low phase.

Top module: `gear_clock_div`

## Requirements
- R1: `half_src` = 0 makes the source period 2 ticks, which is one oscillator period. `half_src` = 1 makes it 4 ticks.
- R2: `gear_code` 0, 1, 2 and 3 multiply the source period by 1, 2, 4 and 8 to give the output period. The output period therefore ranges from 2 to 32 ticks.
- R3: In every output period, `gear_clk` is high first and then low. The low phase lasts half a source period: 1 tick when `half_src` = 0 and 2 ticks when `half_src` = 1. The high phase takes the remaining ticks of the period.
- R4: With `gear_code` = 0, the high phase and the low phase are equal for either value of `half_src`.
- R5: With `half_src` = 1 and `gear_code` = 2, the period is 16 ticks, with 14 ticks high and 2 ticks low. At an oscillator rate equal to half the `clk` rate, this is 7/8 high and 1/8 low.
- R6: `half_src` and `gear_code` are sampled only on the tick that ends an output period. A change made partway through a period leaves the length and the high time of that period unchanged. The new selection applies from the next period.
- R7: While `rst_n` is low, `gear_clk` and `cyc_start` are both 0. On the first `clk` edge with `rst_n` high, a new period begins: `gear_clk` rises, `cyc_start` pulses, and the selection present on the pins at that edge is used.
- R8: `cyc_start` is high for exactly one tick per output period. That tick is the one on which `gear_clk` rises, and `cyc_start` is never high on any other tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock at twice the oscillator rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_src | input | 1 | 1 halves the oscillator before the gear stage |
| gear_code | input | 2 | Gear select: 0 = ÷1, 1 = ÷2, 2 = ÷4, 3 = ÷8 |
| gear_clk | output | 1 | Divided output clock, driven from a register |
| cyc_start | output | 1 | One-tick strobe at each rising edge of `gear_clk` |

## Verification
The bench builds the block with its package defaults: a 2-bit gear code, which gives periods of 2 to 32 ticks. All eight combinations of halving and gear therefore fit in a single table. The bench measures each combination for whole periods, from one strobe to the next. This makes the shortest period (2 ticks, where the strobe recurs on every other tick) and the longest period (32 ticks, with a 2-tick low phase) both directly observable. The same setting also allows a selection change to be placed deep inside the longest period, so that a truncated period would be easy to see.

// File: rtl/gear_div_pkg.sv
package gear_div_pkg;
  localparam int GEAR_W    = 2;
  localparam int MAX_SHIFT = (1 << GEAR_W) - 1;
  localparam int TICK_W    = MAX_SHIFT + 3;

  typedef logic [GEAR_W-1:0] gear_code_t;
  typedef logic [TICK_W-1:0] tick_t;

  typedef struct packed {
    logic       half_src;
    gear_code_t gear;
  } gear_sel_t;

  localparam gear_sel_t SEL_RESET = '{half_src: 1'b0, gear: '0};
  // final tick of an undivided x1 period (2 ticks long)
  localparam tick_t RESET_LAST_TICK = tick_t'(1);
endpackage

// File: rtl/gear_timing.sv
module gear_timing
  import gear_div_pkg::*;
(
  input  gear_sel_t sel,
  output tick_t     last_tick,
  output tick_t     high_len
);
  tick_t src_ticks;
  tick_t low_ticks;
  tick_t period;

  always_comb begin
    src_ticks = sel.half_src ? tick_t'(4) : tick_t'(2);
    low_ticks = sel.half_src ? tick_t'(2) : tick_t'(1);
    period    = src_ticks << sel.gear;
    last_tick = period - tick_t'(1);
    high_len  = period - low_ticks;
  end
endmodule

// File: rtl/gear_sel_reg.sv
module gear_sel_reg
  import gear_div_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  gear_sel_t sel_in,
  output gear_sel_t sel_act,
  output gear_sel_t sel_next
);
  gear_sel_t sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= SEL_RESET;
    else if (load) sel_q <= sel_in;
  end

  assign sel_act  = sel_q;
  assign sel_next = load ? sel_in : sel_q;
endmodule

// File: rtl/gear_phase_ctr.sv
module gear_phase_ctr
  import gear_div_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  tick_t last_tick,
  input  tick_t high_len_next,
  output logic  wrap,
  output logic  clk_q,
  output logic  start_q
);
  tick_t cnt;
  tick_t cnt_nxt;

  assign wrap    = (cnt == last_tick);
  assign cnt_nxt = wrap ? '0 : cnt + tick_t'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= RESET_LAST_TICK;
      clk_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      cnt     <= cnt_nxt;
      clk_q   <= (cnt_nxt < high_len_next);
      start_q <= wrap;
    end
  end
endmodule

// File: rtl/gear_clock_div.sv
module gear_clock_div
  import gear_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_src,
  input  logic [GEAR_W-1:0] gear_code,
  output logic              gear_clk,
  output logic              cyc_start
);
  gear_sel_t sel_pins;
  gear_sel_t sel_act;
  gear_sel_t sel_next;
  tick_t     last_act;
  tick_t     high_act;
  tick_t     last_nxt;
  tick_t     high_nxt;
  logic      wrap;

  assign sel_pins = '{half_src: half_src, gear: gear_code};

  gear_sel_reg u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wrap),
    .sel_in  (sel_pins),
    .sel_act (sel_act),
    .sel_next(sel_next)
  );

  // timing of the period in progress decides where it ends
  gear_timing u_tim_act (
    .sel      (sel_act),
    .last_tick(last_act),
    .high_len (high_act)
  );

  // timing of the selection that owns the next tick shapes the output
  gear_timing u_tim_nxt (
    .sel      (sel_next),
    .last_tick(last_nxt),
    .high_len (high_nxt)
  );

  gear_phase_ctr u_ctr (
    .clk          (clk),
    .rst_n        (rst_n),
    .last_tick    (last_act),
    .high_len_next(high_nxt),
    .wrap         (wrap),
    .clk_q        (gear_clk),
    .start_q      (cyc_start)
  );

  logic unused_ok;
  assign unused_ok = ^{high_act, last_nxt};
endmodule

// File: rtl/gear_clock_div_chk.sv
module gear_clock_div_chk (
  input logic clk,
  input logic rst_n,
  input logic gear_clk,
  input logic cyc_start
);
  logic [2:0] low_run;
  logic [5:0] high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= '0;
    end else begin
      low_run  <= gear_clk ? 3'd0 : ((low_run == 3'd7) ? low_run : low_run + 3'd1);
      high_run <= !gear_clk ? 6'd0 : ((high_run == 6'd63) ? high_run : high_run + 6'd1);
    end
  end

  AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> (gear_clk && !$past(gear_clk))); // R8
  AST_RISE_HAS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gear_clk) |-> cyc_start); // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start); // R8
  AST_LOW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= 3'd2); // R3
  AST_HIGH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    high_run <= 6'd30); // R2
endmodule

bind gear_clock_div gear_clock_div_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gear_clk (gear_clk),
  .cyc_start(cyc_start)
);

// File: tb/gear_clock_div_tb.sv
`timescale 1ns/1ps
module gear_clock_div_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_src = 1'b0;
  logic [1:0] gear_code = 2'd0;
  logic       gear_clk;
  logic       cyc_start;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  gear_clock_div u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .half_src (half_src),
    .gear_code(gear_code),
    .gear_clk (gear_clk),
    .cyc_start(cyc_start)
  );

  // {half_src, gear_code, period ticks[5:0], high ticks[5:0]} from R1..R3
  localparam logic [14:0] VEC [8] = '{
    {1'b0, 2'd0, 6'd2,  6'd1},
    {1'b1, 2'd3, 6'd32, 6'd30},
    {1'b0, 2'd2, 6'd8,  6'd7},
    {1'b1, 2'd0, 6'd4,  6'd2},
    {1'b0, 2'd3, 6'd16, 6'd15},
    {1'b1, 2'd1, 6'd8,  6'd6},
    {1'b0, 2'd1, 6'd4,  6'd3},
    {1'b1, 2'd2, 6'd16, 6'd14}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_start();
    int guard = 0;
    @(negedge clk);
    while (!cyc_start && guard < 200) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // called on a negedge where cyc_start is high; returns on the next one
  task automatic measure(output int per, output int hi, output int starts);
    per = 0; hi = 0; starts = 0;
    do begin
      per++;
      if (gear_clk) hi++;
      if (cyc_start) starts++;
      @(negedge clk);
    end while (!cyc_start && per < 100);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL R7 watchdog expired: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    int per, hi, st;
    // R7: outputs held low in reset
    repeat (3) @(negedge clk);
    check("R7", "gear_clk in reset", int'(gear_clk), 0);
    check("R7", "cyc_start in reset", int'(cyc_start), 0);
    half_src = 1'b1; gear_code = 2'd1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", "gear_clk first tick", int'(gear_clk), 1);
    check("R7", "cyc_start first tick", int'(cyc_start), 1);
    measure(per, hi, st);
    check("R7", "first period uses pins", per, 8);

    // R1 R2 R3: table walk over every selection
    for (int i = 0; i < 8; i++) begin
      half_src  = VEC[i][14];
      gear_code = VEC[i][13:12];
      wait_start();
      measure(per, hi, st);
      check("R1/R2", "period", per, int'(VEC[i][11:6]));
      check("R3", "high ticks", hi, int'(VEC[i][5:0]));
      check("R8", "strobes per period", st, 1);
    end

    // R4: x1 gear duty is even for both source settings
    for (int h = 0; h < 2; h++) begin
      half_src = h[0]; gear_code = 2'd0;
      wait_start();
      measure(per, hi, st);
      check("R4", "twice high equals period", 2 * hi, per);
    end

    // R5: halved source, divide by 4
    half_src = 1'b1; gear_code = 2'd2;
    wait_start();
    measure(per, hi, st);
    check("R5", "period", per, 16);
    check("R5", "low ticks", per - hi, 2);

    // R6: change inside the longest period
    half_src = 1'b1; gear_code = 2'd3;
    wait_start();
    per = 0; hi = 0;
    do begin
      per++;
      if (gear_clk) hi++;
      if (per == 5) begin half_src = 1'b0; gear_code = 2'd0; end
      @(negedge clk);
    end while (!cyc_start && per < 100);
    check("R6", "period after mid change", per, 32);
    check("R6", "high after mid change", hi, 30);
    measure(per, hi, st);
    check("R6", "next period", per, 2);
    check("R6", "next high", hi, 1);

    // R7: reset in the middle of a period
    half_src = 1'b1; gear_code = 2'd3;
    wait_start();
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R7", "gear_clk after mid reset", int'(gear_clk), 0);
    check("R7", "cyc_start after mid reset", int'(cyc_start), 0);
    half_src = 1'b0; gear_code = 2'd2;
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", "restart strobe", int'(cyc_start), 1);
    measure(per, hi, st);
    check("R7", "restart period", per, 8);

    summary();
    $finish;
  end
endmodule